// File: doc/BRIEF.md
# Microinstruction Timing Sequencer

This block produces the timing for each microinstruction. Every instruction runs a source phase and then an execute phase. Each phase lasts one or more minor ticks, and each minor tick lasts `SUB_TICKS` cycles of the fast clock. The sequencer drives four outputs:

- a one-cycle microinstruction clock enable that closes the instruction,
- a source-phase level,
- a one-cycle operand capture enable, which makes the operand registers load on the edge that opens the execute phase,
- a RAM write enable that is only ever active inside the middle of a minor tick.

A timing word is sampled at the end of every instruction. It can stretch the source phase and the execute phase independently. It can also add one tick after the execute phase for a slow destination, and it can request a destination write. Extra controls let a halt input block the next microinstruction clock, and let a step mode advance the machine one minor tick per request.

Top module: `useq_timing`

## Requirements
- R1: While `rst_ni` is low, `uclk_en_o`, `wr_en_o`, `opnd_cap_o` and `src_phase_o` are low. In the first cycle after reset is released, `uclk_en_o` is high.
- R2: An instruction is made of source ticks followed by execute ticks. `src_phase_o` is high for exactly the source ticks. `uclk_en_o` is high for one cycle, in the last sub-cycle of the last tick, and the next cycle begins a source phase.
- R3: The timing inputs (`slow_src_i`, `slow_exe_i`, `slow_dst_i`, `wr_req_i`) are sampled on the clock edge at which `uclk_en_o` is high. They govern the instruction that starts after that edge.
- R4: `slow_src_i`=1 gives the source phase `SLOW_TICKS` ticks. `slow_src_i`=0 gives it one tick.
- R5: `slow_exe_i`=1 gives the execute phase `SLOW_TICKS` ticks. `slow_exe_i`=0 gives it one tick.
- R6: `slow_dst_i`=1 appends one tick after the execute phase. The destination write then falls in that final tick, just before the next microinstruction clock.
- R7: `opnd_cap_o` is high for one cycle per instruction, in the last sub-cycle of the last source tick.
- R8: `wr_en_o` is active only at sub-cycle offsets 1 to `SUB_TICKS`-2 of a minor tick. It is never active at offset 0 or at the last offset.
- R9: With `wr_req_i`=1 and `slow_dst_i`=0, `wr_en_o` is asserted in the first execute tick. With `wr_req_i`=0, `wr_en_o` stays low for the whole instruction.
- R10: When `halt_i` is high at an instruction boundary, `uclk_en_o` stays low and the sequencer holds its position. `uclk_en_o` rises in the same cycle that `halt_i` falls.
- R11: With `step_mode_i`=1, the sequencer waits at offset 0 of each tick. Each `step_i` pulse runs exactly one minor tick.
- R12: An instruction lasts (source ticks + execute ticks + slow-destination tick) × `SUB_TICKS` cycles when it is neither halted nor stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast state clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_src_i | input | 1 | Stretch the source phase of the next instruction |
| slow_exe_i | input | 1 | Stretch the execute phase of the next instruction |
| slow_dst_i | input | 1 | Append a slow-destination tick to the next instruction |
| wr_req_i | input | 1 | The next instruction writes its destination |
| halt_i | input | 1 | Block the microinstruction clock at the boundary |
| step_mode_i | input | 1 | Run one minor tick per step request |
| step_i | input | 1 | Step request (one cycle) |
| uclk_en_o | output | 1 | Microinstruction clock enable |
| src_phase_o | output | 1 | Source phase active |
| opnd_cap_o | output | 1 | Operand register capture enable |
| wr_en_o | output | 1 | RAM write enable, windowed |

## Verification
The bench builds the block with `SUB_TICKS`=5 and `SLOW_TICKS`=2. The odd tick length gives a write window of three cycles with distinct leading and trailing guard cycles. The bench walks all eight combinations of the stretch and slow-destination bits and then runs random timing words, so every instruction length from 10 to 25 cycles and every write-tick placement is checked. With these values, a stepped instruction needs four step pulses, and a halt held through many tick lengths confirms that the boundary really freezes.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef struct packed {
    logic slow_src;
    logic slow_exe;
    logic slow_dst;
    logic wr_req;
  } uword_t;

endpackage

// File: rtl/useq_subtick.sv
module useq_subtick #(
  parameter int unsigned SUB_TICKS = 4,
  parameter int unsigned SUB_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             step_mode_i,
  input  logic             step_i,
  output logic [SUB_W-1:0] sub_o,
  output logic             first_o,
  output logic             last_o,
  output logic             win_o,
  output logic             adv_o
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_TICKS - 1);
  localparam logic [SUB_W-1:0] WIN_LAST = SUB_W'(SUB_TICKS - 2);

  logic [SUB_W-1:0] sub_q;
  logic             step_wait;

  assign first_o   = (sub_q == '0);
  assign last_o    = (sub_q == SUB_LAST);
  assign win_o     = !first_o && (sub_q <= WIN_LAST);
  // step mode parks at offset 0 until a request arrives
  assign step_wait = step_mode_i && first_o && !step_i;
  assign adv_o     = run_i && !hold_i && !step_wait;
  assign sub_o     = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= SUB_LAST;
    end else if (adv_o) begin
      sub_q <= last_o ? '0 : sub_q + 1'b1;
    end
  end

  AST_STEP_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_mode_i && first_o && !step_i) |=> first_o); // R11

  AST_HOLD_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i) |=> $stable(sub_q)); // R10

endmodule

// File: rtl/useq_phase.sv
module useq_phase
  import useq_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 2,
  parameter int unsigned TICK_W     = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   adv_i,
  input  logic   last_sub_i,
  input  logic   win_i,
  input  logic   halt_i,
  input  uword_t word_i,
  output logic   boundary_o,
  output logic   uclk_en_o,
  output logic   src_phase_o,
  output logic   opnd_cap_o,
  output logic   wr_en_o
);

  localparam logic [TICK_W-1:0] ONE  = TICK_W'(1);
  localparam logic [TICK_W-1:0] SLOW = TICK_W'(SLOW_TICKS);

  uword_t            word_q;
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] src_n;
  logic [TICK_W-1:0] exe_n;
  logic [TICK_W-1:0] tot_n;
  logic [TICK_W-1:0] wr_tick;
  logic              last_tick;

  assign src_n     = word_q.slow_src ? SLOW : ONE;
  assign exe_n     = word_q.slow_exe ? SLOW : ONE;
  assign tot_n     = src_n + exe_n + TICK_W'(word_q.slow_dst);
  assign last_tick = (tick_q == tot_n - ONE);
  // slow destination writes in the appended tick, otherwise first execute tick
  assign wr_tick   = word_q.slow_dst ? (tot_n - ONE) : src_n;

  assign boundary_o  = last_sub_i && last_tick;
  assign uclk_en_o   = run_i && boundary_o && !halt_i;
  assign src_phase_o = run_i && (tick_q < src_n);
  assign opnd_cap_o  = run_i && last_sub_i && (tick_q == src_n - ONE);
  assign wr_en_o     = run_i && word_q.wr_req && win_i && (tick_q == wr_tick);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      tick_q <= ONE;
    end else if (adv_i && last_sub_i) begin
      if (last_tick) begin
        tick_q <= '0;
        word_q <= word_i;
      end else begin
        tick_q <= tick_q + ONE;
      end
    end
  end

  AST_HALT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !uclk_en_o); // R10

  AST_UCLK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uclk_en_o |=> src_phase_o); // R2

  AST_UCLK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uclk_en_o |=> !uclk_en_o); // R2

  AST_OPND_EXE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_cap_o |=> !src_phase_o); // R7

  AST_SLOW_DST_EXE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && word_q.slow_dst) |-> !src_phase_o); // R6

  AST_CFG_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uclk_en_o |=> (word_q == $past(word_i))); // R3

endmodule

// File: rtl/useq_timing.sv
module useq_timing
  import useq_pkg::*;
#(
  parameter int unsigned SUB_TICKS  = 4,
  parameter int unsigned SLOW_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_src_i,
  input  logic slow_exe_i,
  input  logic slow_dst_i,
  input  logic wr_req_i,
  input  logic halt_i,
  input  logic step_mode_i,
  input  logic step_i,
  output logic uclk_en_o,
  output logic src_phase_o,
  output logic opnd_cap_o,
  output logic wr_en_o
);

  localparam int unsigned SUB_W  = $clog2(SUB_TICKS);
  localparam int unsigned TICK_W = $clog2(2 * SLOW_TICKS + 2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_TICKS - 1);

  logic             run_q;
  logic [SUB_W-1:0] sub;
  logic             sub_first;
  logic             sub_last;
  logic             sub_win;
  logic             adv;
  logic             boundary;
  logic             hold;
  uword_t           word;

  assign word = '{slow_src: slow_src_i, slow_exe: slow_exe_i,
                  slow_dst: slow_dst_i, wr_req: wr_req_i};
  assign hold = boundary && halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  useq_subtick #(
    .SUB_TICKS (SUB_TICKS),
    .SUB_W     (SUB_W)
  ) i_subtick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .hold_i      (hold),
    .step_mode_i (step_mode_i),
    .step_i      (step_i),
    .sub_o       (sub),
    .first_o     (sub_first),
    .last_o      (sub_last),
    .win_o       (sub_win),
    .adv_o       (adv)
  );

  useq_phase #(
    .SLOW_TICKS (SLOW_TICKS),
    .TICK_W     (TICK_W)
  ) i_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .adv_i       (adv),
    .last_sub_i  (sub_last),
    .win_i       (sub_win),
    .halt_i      (halt_i),
    .word_i      (word),
    .boundary_o  (boundary),
    .uclk_en_o   (uclk_en_o),
    .src_phase_o (src_phase_o),
    .opnd_cap_o  (opnd_cap_o),
    .wr_en_o     (wr_en_o)
  );

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!uclk_en_o && !wr_en_o && !opnd_cap_o); // R1
    end
  end

  AST_WIN_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (sub != '0 && sub != SUB_LAST)); // R8

  AST_UCLK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uclk_en_o |-> (sub == SUB_LAST && !sub_first)); // R2

endmodule

// File: tb/test_useq_timing.sv
`timescale 1ns/1ps
module test_useq_timing;

  localparam int N    = 5;
  localparam int SLOW = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic slow_src_i = 0, slow_exe_i = 0, slow_dst_i = 0, wr_req_i = 0;
  logic halt_i = 0, step_mode_i = 0, step_i = 0;
  logic uclk_en_o, src_phase_o, opnd_cap_o, wr_en_o;

  always #4 clk_i = ~clk_i;

  useq_timing #(.SUB_TICKS(N), .SLOW_TICKS(SLOW)) i_useq_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .slow_src_i(slow_src_i), .slow_exe_i(slow_exe_i),
    .slow_dst_i(slow_dst_i), .wr_req_i(wr_req_i),
    .halt_i(halt_i), .step_mode_i(step_mode_i), .step_i(step_i),
    .uclk_en_o(uclk_en_o), .src_phase_o(src_phase_o),
    .opnd_cap_o(opnd_cap_o), .wr_en_o(wr_en_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ticks_of(input logic slow);
    return slow ? SLOW : 1;
  endfunction

  // monitor state
  bit mon_en = 1, rand_en = 1, pending = 0, have_cur = 0;
  int dir_idx = 0, n_instr = 0;
  logic c_ss, c_se, c_sd, c_wr;
  int cyc, src_cnt, wr_cnt, wr_first, opnd_n, opnd_k, wr_at_uclk;

  initial begin
    void'($urandom(32'd1234));
    forever begin
      @(negedge clk_i);
      if (pending) begin
        pending = 0;
        if (dir_idx < 9) begin
          {slow_src_i, slow_exe_i, slow_dst_i} = 3'(dir_idx % 8);
          wr_req_i = (dir_idx != 8);
          dir_idx++;
        end else begin
          {slow_src_i, slow_exe_i, slow_dst_i, wr_req_i} = 4'($urandom);
        end
      end
      #1;
      if (mon_en) begin
        if (src_phase_o) src_cnt++;
        if (wr_en_o) begin
          if (wr_cnt == 0) wr_first = cyc;
          wr_cnt++;
        end
        if (opnd_cap_o) begin opnd_n++; opnd_k = cyc; end
        if (uclk_en_o && wr_en_o) wr_at_uclk++;
        cyc++;
        if (uclk_en_o) begin
          if (have_cur) begin
            automatic int s = ticks_of(c_ss);
            automatic int e = ticks_of(c_se);
            automatic int t = s + e + int'(c_sd);
            chk("R12 instruction length", cyc, t * N);
            chk(c_ss ? "R4 source ticks stretched" : "R2 source ticks", src_cnt, s * N);
            chk(c_se ? "R5 execute stretch" : "R3 word sampled", cyc - src_cnt, (e + int'(c_sd)) * N);
            chk("R7 operand pulse count", opnd_n, 1);
            chk("R7 operand pulse position", opnd_k, s * N - 1);
            chk("R8 write window width", wr_cnt, c_wr ? N - 2 : 0);
            chk("R8 no write at boundary", wr_at_uclk, 0);
            if (c_wr)
              chk(c_sd ? "R6 slow destination write tick" : "R9 fast write tick",
                  wr_first, c_sd ? (t - 1) * N + 1 : s * N + 1);
            n_instr++;
          end
          c_ss = slow_src_i; c_se = slow_exe_i; c_sd = slow_dst_i; c_wr = wr_req_i;
          have_cur = 1;
          cyc = 0; src_cnt = 0; wr_cnt = 0; wr_first = 0;
          opnd_n = 0; opnd_k = -1; wr_at_uclk = 0;
          if (rand_en) pending = 1;
        end
      end
    end
  end

  task automatic wait_uclk();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i); #1;
      if (uclk_en_o) return;
    end
    chk("R2 uclk timeout", 0, 1);
  endtask

  initial begin
    int cnt;
    int src_hold;
    int pulses;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 reset uclk", uclk_en_o, 0);
    chk("R1 reset write", wr_en_o, 0);
    chk("R1 reset operand", opnd_cap_o, 0);
    chk("R1 reset source", src_phase_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 first uclk after reset", uclk_en_o, 1);

    wait (n_instr >= 150);
    rand_en = 0;
    wait_uclk();
    mon_en = 0;
    // halt: S=2 E=1 D=0, no write
    @(negedge clk_i);
    {slow_src_i, slow_exe_i, slow_dst_i, wr_req_i} = 4'b1000;
    wait_uclk();
    @(negedge clk_i);
    halt_i = 1;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); #1;
      if (uclk_en_o) cnt++;
    end
    chk("R10 no uclk while halted", cnt, 0);
    chk("R10 held in execute phase", src_phase_o, 0);
    // next word: S=2 E=1 D=1 -> four ticks
    @(negedge clk_i);
    slow_dst_i = 1;
    halt_i = 0;
    #1;
    chk("R10 uclk on halt release", uclk_en_o, 1);
    @(negedge clk_i);
    step_mode_i = 1;
    #1;
    chk("R2 source after uclk", src_phase_o, 1);
    cnt = 0; src_hold = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i); #1;
      if (uclk_en_o) cnt++;
      if (src_phase_o) src_hold++;
    end
    chk("R11 parked: no uclk", cnt, 0);
    chk("R11 parked: source held", src_hold, 10);
    pulses = 0;
    for (int p = 1; p <= 6 && pulses == 0; p++) begin
      @(negedge clk_i);
      step_i = 1;
      #1;
      if (uclk_en_o) pulses = p;
      @(negedge clk_i);
      step_i = 0;
      for (int i = 0; i < N + 1; i++) begin
        #1;
        if (uclk_en_o && pulses == 0) pulses = p;
        @(negedge clk_i);
      end
    end
    chk("R11 step pulses per instruction", pulses, 4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule